// File: doc/BRIEF.md
# PWM Fault Shutdown Controller

This block sits between a PWM generator and its output drivers and forces the PWM outputs to their inactive level whenever an external fault input is asserted. The fault input is taken from one of several candidate pins chosen by a select field. The raw pin level drives the shutdown output through gates only, so the outputs turn off without waiting for a clock edge. A synchronized copy of the pin feeds a sticky event flag, an interrupt request and the shutdown latch that keeps the outputs off after the pin returns low.

Two release policies are available. In automatic mode, the outputs come back on the first PWM cycle-start pulse that arrives while the synchronized fault level is low, and acknowledging the event flag has no effect on them. In manual mode, software must first acknowledge while the fault level is low, and the outputs then resume at the next cycle-start pulse. The pin stays readable through a status bit, and selecting it as the fault source does not take it away from any other logic.

Top module: `pwm_fault_guard`

## Requirements
- R1: While `fault_en` is 1 and the selected raw fault pin is 1, `pwm_disable` is 1 in the same cycle, before any clock edge.
- R2: `pin_sel` = 0 selects `fault_pins[0]` and `pin_sel` = 1 selects `fault_pins[1]`. A pin that is not selected has no effect on `pwm_disable`, `event_flag` or `pin_level`.
- R3: `pin_level` shows the selected pin level two clock edges after the pin changes, whether or not `fault_en` is set. It is a status output only and cannot be written.
- R4: `event_flag` is set by each synchronized rising edge of the selected pin while `fault_en` is 1. It stays set until a one-cycle pulse on `ack` clears it.
- R5: If an `ack` pulse arrives in the same clock as a synchronized rising edge, `event_flag` ends up set.
- R6: With `auto_mode` = 1, the outputs are re-enabled by the first `cycle_start` pulse seen while the synchronized pin level is low. A `cycle_start` pulse while that level is still high leaves `pwm_disable` at 1.
- R7: With `auto_mode` = 1, an `ack` clears `event_flag` but leaves `pwm_disable` at 1.
- R8: With `auto_mode` = 0, an `ack` given while the synchronized pin level is high does not release the latch. `pwm_disable` stays 1 through later `cycle_start` pulses.
- R9: With `auto_mode` = 0, an `ack` given while the synchronized pin level is low arms the release. `pwm_disable` stays 1 until the next `cycle_start` pulse and goes to 0 after it.
- R10: `irq` is 1 exactly when `event_flag` is 1 and `irq_en` is 1.
- R11: While `fault_en` is 0, the pin drives neither `pwm_disable` nor `event_flag`, and any latched shutdown is released.
- R12: A synchronous reset clears `event_flag` and the shutdown latch, so `pwm_disable` and `irq` read 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fault_pins | input | NUM_PINS | Raw, asynchronous candidate fault pins |
| pin_sel | input | SEL_W | Index of the pin used as the fault source |
| fault_en | input | 1 | Enables the fault function |
| auto_mode | input | 1 | 1 = automatic release, 0 = manual release |
| ack | input | 1 | One-cycle acknowledge pulse (write-one-to-clear) |
| irq_en | input | 1 | Interrupt enable |
| cycle_start | input | 1 | One-cycle pulse at each PWM period boundary |
| pwm_disable | output | 1 | Forces PWM outputs inactive |
| pin_level | output | 1 | Synchronized level of the selected pin |
| event_flag | output | 1 | Sticky fault event flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench runs the full fault, acknowledge and release sequence for every pin select and both release modes. A design that waited for a clock before shutting down, or that listened to the unselected pin, is caught within one cycle. It pulses `cycle_start` while the synchronizer still holds a high level, and gives a manual acknowledge while the pin is high. A release that keyed off the raw pin, or an acknowledge that ignored the pin level, would turn the outputs back on early in those cases. It also lands an acknowledge exactly on the rising-edge clock, where a design with clear-over-set priority loses the event. Finally it drops `fault_en` while a shutdown is latched, which exposes a latch that is not released.

// File: rtl/pwmf_pkg.sv
package pwmf_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_FAULT = 2'd1,
    ST_ARMED = 2'd2
  } trip_state_t;
endpackage

// File: rtl/pwmf_sync.sv
module pwmf_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic level,
  output logic rise
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], din};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign level = chain_q[STAGES-1];
  assign rise  = chain_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/pwmf_flag.sv
module pwmf_flag (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic rise,
  input  logic ack,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst)                flag <= 1'b0;
    else if (enable && rise) flag <= 1'b1;
    else if (ack)           flag <= 1'b0;
  end

  // R4: the flag holds until an acknowledge
  p_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    flag && !ack |=> flag);
  // R5: a rising edge wins over a same-cycle acknowledge
  p_set_wins_r5: assert property (@(posedge clk) disable iff (rst)
    enable && rise |=> flag);
endmodule

// File: rtl/pwmf_trip.sv
module pwmf_trip
  import pwmf_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        enable,
  input  logic        auto_mode,
  input  logic        level,
  input  logic        ack,
  input  logic        cycle_start,
  output trip_state_t state
);
  trip_state_t nxt;

  always_comb begin
    nxt = state;
    if (!enable) begin
      nxt = ST_RUN;
    end else if (level) begin
      nxt = ST_FAULT;
    end else begin
      case (state)
        ST_FAULT: begin
          if (auto_mode) begin
            if (cycle_start) nxt = ST_RUN;
          end else if (ack) begin
            nxt = ST_ARMED;
          end
        end
        ST_ARMED: if (cycle_start) nxt = ST_RUN;
        default:  nxt = state;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_RUN;
    else     state <= nxt;
  end

  // R8: a high level keeps the latch set whatever else happens
  p_hold_high_r8: assert property (@(posedge clk) disable iff (rst)
    enable && level |=> state == ST_FAULT);
  // R6: release only happens on a cycle boundary
  p_cycle_only_r6: assert property (@(posedge clk) disable iff (rst)
    enable && state != ST_RUN && !cycle_start |=> state != ST_RUN);
  // R9: manual mode never goes straight from fault to running
  p_manual_two_step_r9: assert property (@(posedge clk) disable iff (rst)
    enable && !auto_mode && state == ST_FAULT |=> state != ST_RUN);
endmodule

// File: rtl/pwm_fault_guard.sv
module pwm_fault_guard
  import pwmf_pkg::*;
#(
  parameter int NUM_PINS    = 2,
  parameter int SYNC_STAGES = 2,
  localparam int SEL_W      = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] fault_pins,
  input  logic [SEL_W-1:0]    pin_sel,
  input  logic                fault_en,
  input  logic                auto_mode,
  input  logic                ack,
  input  logic                irq_en,
  input  logic                cycle_start,
  output logic                pwm_disable,
  output logic                pin_level,
  output logic                event_flag,
  output logic                irq
);
  logic        raw_sel;
  logic        sync_level;
  logic        sync_rise;
  trip_state_t trip_state;

  assign raw_sel = fault_pins[pin_sel];

  pwmf_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .din   (raw_sel),
    .level (sync_level),
    .rise  (sync_rise)
  );

  pwmf_flag u_flag (
    .clk    (clk),
    .rst    (rst),
    .enable (fault_en),
    .rise   (sync_rise),
    .ack    (ack),
    .flag   (event_flag)
  );

  pwmf_trip u_trip (
    .clk         (clk),
    .rst         (rst),
    .enable      (fault_en),
    .auto_mode   (auto_mode),
    .level       (sync_level),
    .ack         (ack),
    .cycle_start (cycle_start),
    .state       (trip_state)
  );

  assign pin_level   = sync_level;
  assign pwm_disable = fault_en & (raw_sel | (trip_state != ST_RUN));
  assign irq         = event_flag & irq_en;

  // R1: a latched shutdown always reaches the output
  p_latch_blocks_r1: assert property (@(posedge clk) disable iff (rst)
    fault_en && trip_state != ST_RUN |-> pwm_disable);
endmodule

// File: tb/sim_pwm_fault_guard.sv
`timescale 1ns/1ps
module sim_pwm_fault_guard;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] pins = 2'b00;
  logic [0:0] sel = 1'b0;
  logic       en = 1'b1, auto_m = 1'b0, ack = 1'b0, irq_en = 1'b1, cs = 1'b0;
  logic       pwm_disable, pin_level, event_flag, irq;
  int         checks = 0, errors = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  pwm_fault_guard #(.NUM_PINS(2), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst(rst), .fault_pins(pins), .pin_sel(sel),
    .fault_en(en), .auto_mode(auto_m), .ack(ack), .irq_en(irq_en),
    .cycle_start(cs), .pwm_disable(pwm_disable), .pin_level(pin_level),
    .event_flag(event_flag), .irq(irq)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_ack();
    ack = 1'b1; step(1); ack = 1'b0;
  endtask

  task automatic pulse_cs();
    cs = 1'b1; step(1); cs = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1; step(2); rst = 1'b0; step(1);
  endtask

  initial begin
    step(3);
    rst = 1'b0;
    step(1);
    chk("R12 reset disable", pwm_disable, 1'b0);
    chk("R12 reset flag", event_flag, 1'b0);
    chk("R12 reset irq", irq, 1'b0);

    for (int s = 0; s < 2; s++) begin
      for (int m = 0; m < 2; m++) begin
        pins = 2'b00; sel = s[0]; auto_m = m[0];
        do_reset();
        // unselected pin must not matter
        pins[1-s] = 1'b1; step(4);
        chk("R2 other pin disable", pwm_disable, 1'b0);
        chk("R2 other pin flag", event_flag, 1'b0);
        chk("R2 other pin level", pin_level, 1'b0);
        pins[1-s] = 1'b0; step(1);
        // fault on selected pin: immediate shutdown
        pins[s] = 1'b1; #1;
        chk("R1 immediate disable", pwm_disable, 1'b1);
        step(3);
        chk("R3 level follows", pin_level, 1'b1);
        chk("R4 flag set", event_flag, 1'b1);
        chk("R10 irq on", irq, 1'b1);
        irq_en = 1'b0; #1;
        chk("R10 irq masked", irq, 1'b0);
        irq_en = 1'b1;
        if (m == 1) begin
          pins[s] = 1'b0;
          pulse_cs(); // synchronizer still high
          chk("R6 early cycle ignored", pwm_disable, 1'b1);
          pulse_ack();
          chk("R7 ack clears flag", event_flag, 1'b0);
          chk("R7 ack keeps disable", pwm_disable, 1'b1);
          step(3);
          chk("R6 waits for cycle", pwm_disable, 1'b1);
          pulse_cs();
          chk("R6 released on cycle", pwm_disable, 1'b0);
        end else begin
          pulse_ack(); // while still high
          chk("R8 ack high disable", pwm_disable, 1'b1);
          pins[s] = 1'b0; step(3);
          pulse_cs();
          chk("R8 stays latched", pwm_disable, 1'b1);
          pulse_ack();
          chk("R9 armed not released", pwm_disable, 1'b1);
          step(2);
          chk("R9 still waits", pwm_disable, 1'b1);
          pulse_cs();
          chk("R9 released on cycle", pwm_disable, 1'b0);
        end
      end
    end

    // R5: ack lands on the same clock as the rising edge
    pins = 2'b00; sel = 1'b0; auto_m = 1'b1;
    do_reset();
    pins[0] = 1'b1; step(2);
    ack = 1'b1; step(1); ack = 1'b0;
    chk("R5 set beats ack", event_flag, 1'b1);

    // R12: reset clears a latched shutdown
    pins[0] = 1'b0; step(3);
    chk("R12 latched before reset", pwm_disable, 1'b1);
    do_reset();
    chk("R12 disable cleared", pwm_disable, 1'b0);
    chk("R12 flag cleared", event_flag, 1'b0);

    // R11: fault function off
    en = 1'b0; pins[0] = 1'b1; #1;
    chk("R11 no disable", pwm_disable, 1'b0);
    step(4);
    chk("R11 no flag", event_flag, 1'b0);
    chk("R11 no irq", irq, 1'b0);
    chk("R3 level while disabled", pin_level, 1'b1);
    en = 1'b1; #1;
    chk("R1 enable with pin high", pwm_disable, 1'b1);
    step(2);
    en = 1'b0; step(2);
    pins[0] = 1'b0; step(3);
    en = 1'b1; #1;
    chk("R11 latch released", pwm_disable, 1'b0);
    step(2);
    chk("R11 stays released", pwm_disable, 1'b0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule